// File: doc/BRIEF.md
# AES Column-Mixing Execution Unit

This unit applies the AES column-mixing step, or its inverse, to a complete 128-bit cipher state. It sits next to a processor core as a custom execution unit. The core hands it a state word, chooses the direction and pulses a start strobe. One clock later the unit returns the transformed state together with a one-cycle done strobe.

The state is column-major. Byte 0 is the most significant byte of the word, and column c holds bytes 4c to 4c+3, with row 0 in its top byte. Each column is multiplied by a fixed circulant matrix over GF(2^8). The forward path and the inverse path are separate xor networks; the inverse network is deeper because its coefficients are larger. The unit does not substitute bytes, rotate rows, add keys or sequence rounds. The core never issues it for the last cipher round, because that round has no column-mixing step.

Top module: `aes_mix_unit`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `done_o` is 0 and `result_o` is all zeros.
- R2: With `inv_i`=0 at start, every output column equals the input column multiplied by the circulant matrix whose first row is {02,03,01,01}.
- R3: With `inv_i`=1 at start, every output column equals the input column multiplied by the circulant matrix whose first row is {0E,0B,0D,09}.
- R4: Byte k of the state is bits [127-8k -: 8]. Column c is bytes 4c..4c+3, ordered from row 0 to row 3. Each column is transformed independently of the other three.
- R5: `done_o` is 1 in exactly the cycle after each cycle in which `start_i` is 1, and is 0 otherwise.
- R6: The direction is sampled only together with `start_i`. A change of `inv_i` while `start_i` is 0 does not alter `result_o`.
- R7: While `start_i` is 0, `result_o` holds its last value whatever `state_i` does.
- R8: Running the inverse transform on the result of the forward transform returns the original state.
- R9: Starts on consecutive cycles, including starts that alternate direction, each produce a correct result in the cycle after their own start.
- R10: Doubling in GF(2^8) reduces by 0x1B when bit 7 is set. For example, the column db,13,53,45 maps forward to 8e,4d,a1,bc.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Issue strobe: sample the state and the direction |
| inv_i | input | 1 | 0 selects the forward transform, 1 the inverse |
| state_i | input | 128 | State to transform, byte 0 in bits [127:120] |
| result_o | output | 128 | Registered transformed state |
| done_o | output | 1 | One-cycle strobe marking a new result |

## Verification
Two functions can fall in the same cycle: the result of one issue is delivered while the next state and direction are captured. The bench provokes this by raising start on consecutive cycles and alternating forward and inverse. In each of those cycles it checks that done is 1 and that the result belongs to the issue made one cycle earlier. It also changes direction and state while start is low and checks that the held result stays unchanged.

// File: rtl/aes_mix_pkg.sv
package aes_mix_pkg;

  localparam int BYTE_W   = 8;
  localparam int ROWS     = 4;
  localparam int COLS     = 4;
  localparam int COL_W    = ROWS * BYTE_W;
  localparam int STATE_W  = COLS * COL_W;
  localparam logic [BYTE_W-1:0] REDUCE = 8'h1B;

  typedef logic [BYTE_W-1:0] gf_byte_t;
  typedef logic [COL_W-1:0]  col_t;
  typedef logic [STATE_W-1:0] state_t;

  typedef enum logic {DIR_FWD = 1'b0, DIR_INV = 1'b1} mix_dir_e;

  // doubling modulo x^8+x^4+x^3+x+1
  function automatic gf_byte_t gf_dbl(input gf_byte_t b);
    return {b[6:0], 1'b0} ^ (b[7] ? REDUCE : 8'h00);
  endfunction

  function automatic gf_byte_t gf_x3(input gf_byte_t b);
    return gf_dbl(b) ^ b;
  endfunction

  function automatic gf_byte_t gf_x9(input gf_byte_t b);
    return gf_dbl(gf_dbl(gf_dbl(b))) ^ b;
  endfunction

  function automatic gf_byte_t gf_xb(input gf_byte_t b);
    gf_byte_t d1, d3;
    d1 = gf_dbl(b);
    d3 = gf_dbl(gf_dbl(d1));
    return d3 ^ d1 ^ b;
  endfunction

  function automatic gf_byte_t gf_xd(input gf_byte_t b);
    gf_byte_t d2, d3;
    d2 = gf_dbl(gf_dbl(b));
    d3 = gf_dbl(d2);
    return d3 ^ d2 ^ b;
  endfunction

  function automatic gf_byte_t gf_xe(input gf_byte_t b);
    gf_byte_t d1, d2, d3;
    d1 = gf_dbl(b);
    d2 = gf_dbl(d1);
    d3 = gf_dbl(d2);
    return d3 ^ d2 ^ d1;
  endfunction

endpackage

// File: rtl/aes_mix_fwd_col.sv
module aes_mix_fwd_col
  import aes_mix_pkg::*;
(
  input  col_t col_i,
  output col_t col_o
);
  gf_byte_t b [ROWS];
  gf_byte_t y [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_split
    assign b[r] = col_i[COL_W-1-BYTE_W*r -: BYTE_W];
  end

  // circulant rows: 2,3,1,1 rotated right per row
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign y[r] = gf_dbl(b[r]) ^ gf_x3(b[(r+1)%ROWS])
                ^ b[(r+2)%ROWS] ^ b[(r+3)%ROWS];
    assign col_o[COL_W-1-BYTE_W*r -: BYTE_W] = y[r];
  end
endmodule

// File: rtl/aes_mix_inv_col.sv
module aes_mix_inv_col
  import aes_mix_pkg::*;
(
  input  col_t col_i,
  output col_t col_o
);
  gf_byte_t b [ROWS];
  gf_byte_t y [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_split
    assign b[r] = col_i[COL_W-1-BYTE_W*r -: BYTE_W];
  end

  // circulant rows: e,b,d,9 rotated right per row
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign y[r] = gf_xe(b[r]) ^ gf_xb(b[(r+1)%ROWS])
                ^ gf_xd(b[(r+2)%ROWS]) ^ gf_x9(b[(r+3)%ROWS]);
    assign col_o[COL_W-1-BYTE_W*r -: BYTE_W] = y[r];
  end
endmodule

// File: rtl/aes_mix_lane.sv
module aes_mix_lane
  import aes_mix_pkg::*;
(
  input  col_t col_i,
  input  logic inv_i,
  output col_t fwd_o,
  output col_t inv_o,
  output col_t sel_o
);
  aes_mix_fwd_col u_fwd (.col_i(col_i), .col_o(fwd_o));
  aes_mix_inv_col u_inv (.col_i(col_i), .col_o(inv_o));

  assign sel_o = (mix_dir_e'(inv_i) == DIR_INV) ? inv_o : fwd_o;
endmodule

// File: rtl/aes_mix_unit.sv
module aes_mix_unit
  import aes_mix_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         inv_i,
  input  logic [127:0] state_i,
  output logic [127:0] result_o,
  output logic         done_o
);
  state_t fwd_word;
  state_t inv_word;
  state_t sel_word;
  logic   issue;

  assign issue = start_i;

  for (genvar c = 0; c < COLS; c++) begin : g_col
    col_t f_c, i_c, s_c;
    aes_mix_lane u_lane (
      .col_i (state_i[STATE_W-1-COL_W*c -: COL_W]),
      .inv_i (inv_i),
      .fwd_o (f_c),
      .inv_o (i_c),
      .sel_o (s_c)
    );
    assign fwd_word[STATE_W-1-COL_W*c -: COL_W] = f_c;
    assign inv_word[STATE_W-1-COL_W*c -: COL_W] = i_c;
    assign sel_word[STATE_W-1-COL_W*c -: COL_W] = s_c;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result_o <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= issue;
      if (issue) result_o <= sel_word;
    end
  end
endmodule

// File: rtl/aes_mix_unit_chk.sv
module aes_mix_unit_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         start_i,
  input logic         inv_i,
  input logic [127:0] state_i,
  input logic [127:0] result_o,
  input logic         done_o
);
  a_r5_done_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> done_o);

  a_r5_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !done_o);

  a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> $stable(result_o));

  // R4: both transforms are linear, so a zero state maps to zero
  a_r4_zero_maps_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && state_i == '0) |=> (result_o == '0));

  // R2/R3: a nonzero state never maps to zero, because the matrices are invertible
  a_r2_nonzero_image: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && state_i != '0) |=> (result_o != '0));
endmodule

bind aes_mix_unit aes_mix_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .inv_i(inv_i),
  .state_i(state_i), .result_o(result_o), .done_o(done_o)
);

// File: tb/tb_aes_mix_unit.sv
module tb_aes_mix_unit;
  logic         clk = 0;
  logic         rst_n = 0;
  logic         start_i = 0;
  logic         inv_i = 0;
  logic [127:0] state_i = '0;
  logic [127:0] result_o;
  logic         done_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  aes_mix_unit dut (.*);

  function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] k);
    logic [7:0] p = 0;
    logic [7:0] aa = a;
    for (int i = 0; i < 8; i++) begin
      if (k[i]) p ^= aa;
      aa = aa[7] ? ((aa << 1) ^ 8'h1b) : (aa << 1);
    end
    return p;
  endfunction

  function automatic logic [127:0] ref_mix(input logic [127:0] s, input bit inv);
    logic [7:0] coef [4];
    logic [127:0] o = '0;
    if (inv) coef = '{8'h0e, 8'h0b, 8'h0d, 8'h09};
    else     coef = '{8'h02, 8'h03, 8'h01, 8'h01};
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) begin
        logic [7:0] acc = 0;
        for (int j = 0; j < 4; j++)
          acc ^= ref_mul(s[127-8*(4*c+j) -: 8], coef[(j - r + 4) % 4]);
        o[127-8*(4*c+r) -: 8] = acc;
      end
    return o;
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [127:0] s, input bit inv);
    @(negedge clk);
    state_i = s; inv_i = inv; start_i = 1;
    @(negedge clk);
    start_i = 0;
  endtask

  initial begin
    logic [127:0] s, f, col;
    repeat (3) @(negedge clk);
    chk("R1 reset result", result_o, '0);
    chk("R1 reset done", {127'b0, done_o}, 128'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", {result_o[126:0], done_o}, '0);

    // R10 / R4: known column in every column position
    for (int c = 0; c < 4; c++) begin
      s = '0; s[127-32*c -: 32] = 32'hdb135345;
      issue(s, 0);
      col = '0; col[127-32*c -: 32] = 32'h8e4da1bc;
      chk("R10 R4 known column fwd", result_o, col);
      chk("R5 done", {127'b0, done_o}, 128'd1);
      issue(col, 1);
      chk("R3 known column inv", result_o, s);
    end

    // R2 R3 sweep: every byte value in every position
    for (int v = 0; v < 256; v++) begin
      s = '0; s[127-8*(v%16) -: 8] = v[7:0];
      s ^= {16{v[7:0] ^ 8'h5a}} & 128'h00ff_0000_ff00_0000_00ff_0000_ff00_0000;
      issue(s, 0);
      chk("R2 fwd sweep", result_o, ref_mix(s, 0));
      issue(s, 1);
      chk("R3 inv sweep", result_o, ref_mix(s, 1));
    end

    // R8 round trip with random states
    for (int n = 0; n < 100; n++) begin
      s = {$urandom, $urandom, $urandom, $urandom};
      issue(s, 0);
      f = result_o;
      issue(f, 1);
      chk("R8 roundtrip", result_o, s);
    end

    // R6 R7: change inputs with start low
    s = 128'h00112233445566778899aabbccddeeff;
    issue(s, 0);
    f = result_o;
    @(negedge clk);
    chk("R5 done single pulse", {127'b0, done_o}, 128'd0);
    inv_i = 1;
    state_i = ~s;
    repeat (3) @(negedge clk);
    chk("R6 R7 idle hold", result_o, f);

    // R9 back-to-back, alternating direction
    @(negedge clk);
    state_i = s; inv_i = 0; start_i = 1;
    @(negedge clk);
    chk("R9 b2b first", result_o, ref_mix(s, 0));
    chk("R9 b2b done1", {127'b0, done_o}, 128'd1);
    state_i = ~s; inv_i = 1;
    @(negedge clk);
    chk("R9 b2b second", result_o, ref_mix(~s, 1));
    chk("R9 b2b done2", {127'b0, done_o}, 128'd1);
    state_i = 128'h1; inv_i = 0;
    @(negedge clk);
    start_i = 0;
    chk("R9 b2b third", result_o, ref_mix(128'h1, 0));
    @(negedge clk);
    chk("R5 done drops", {127'b0, done_o}, 128'd0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule